// File: doc/BRIEF.md
# Calendar Alarm Match and Interrupt Gate

This block watches the running calendar registers of a real-time clock and raises an alarm when the hour, weekday and day-of-month fields equal the values held in three alarm bytes. The comparison runs once per second, on a single-cycle tick from the timekeeping logic. A match sets a sticky alarm flag. The flag stays set until a clear strobe, which stands for software writing zero to the flag's status bit.

Each alarm byte has a "don't care" bit. Setting it removes that field from the comparison. With every field masked, the alarm fires once every second.

The active-low interrupt output follows the flag only when two conditions hold. The alarm-interrupt enable must be set, and the interrupt/square-wave select must be in interrupt mode. Both control bits sit in a small register that loads on a write strobe. Both clear at reset, so the interrupt stays quiet after power-up.

Top module: `alm_match_irq`

## Requirements
- R1: Each time and alarm field is one byte. Bits [6:0] are compared as raw bits. An alarm byte with bit 7 = 1 excludes its field from the match, and bit 7 of the time fields is ignored. In the hour byte, bit 6 = 1 marks 12-hour mode and bit 5 = 1 marks PM in that mode. A 12-hour alarm therefore never matches a 24-hour time. The hour field uses BCD 00–23 or 1–12, the weekday 1–7 and the day-of-month 01–31.
- R2: When `tick` is high and every unmasked field matches, `alarm_flag` is 1 after the next rising clock edge.
- R3: When `tick` is low, a matching set of fields leaves `alarm_flag` unchanged.
- R4: `flag_clr` clears `alarm_flag` at the next edge. If a tick with a full match arrives in the same cycle, the flag is set instead.
- R5: With neither `tick` nor `flag_clr` high, `alarm_flag` holds its value.
- R6: `irq_n` is 0 exactly when `alarm_flag`, the stored enable and the stored interrupt-mode select are all 1. Otherwise it is 1.
- R7: After reset, `alarm_flag` = 0, the enable and mode bits are 0, and `irq_n` = 1.
- R8: `ctl_wr` loads `ctl_ien` and `ctl_intcn` into the control bits at the next edge. Without `ctl_wr`, changes on those inputs have no effect on `irq_n`.
- R9: With all three alarm bytes masked, every tick sets the flag, whatever the time values are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse once per second |
| cur_hour | input | 8 | Running hours byte |
| cur_day | input | 8 | Running weekday byte |
| cur_date | input | 8 | Running day-of-month byte |
| alm_hour | input | 8 | Alarm hours byte, bit 7 = mask |
| alm_day | input | 8 | Alarm weekday byte, bit 7 = mask |
| alm_date | input | 8 | Alarm day-of-month byte, bit 7 = mask |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_ien | input | 1 | Alarm interrupt enable value to write |
| ctl_intcn | input | 1 | Interrupt-mode select value to write (1 = interrupt) |
| flag_clr | input | 1 | Clears the alarm flag |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench sweeps every pair of 24-hour times and alarms in BCD, every pair of weekdays, and every pair of day-of-month values. A design that compared in binary, or compared too few bits, would report false matches or miss real ones. It also pits a 12-hour PM alarm against the same digits in AM and in 24-hour form; a design that dropped the mode or PM bits would fire twelve hours early. Every mask combination is run with deliberately wrong field values, which exposes a mask bit that is ignored or applied to the wrong field. The bench also drives a clear in the same cycle as a matching tick, where a design giving the clear priority would lose an alarm. All four gating combinations are checked, together with control-input changes made without a write strobe.

// File: rtl/alm_pkg.sv
package alm_pkg;
    typedef struct packed {
        logic flag;
        logic ien;
        logic intcn;
    } alm_state_t;

    localparam alm_state_t ALM_RESET = '{flag: 1'b0, ien: 1'b0, intcn: 1'b0};
endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur_val,
    input  logic [W-1:0] alm_val,
    output logic         hit
);
    localparam int MASK_BIT = W - 1;

    // masked field always agrees; otherwise all value bits must agree
    assign hit = alm_val[MASK_BIT] | (cur_val[MASK_BIT-1:0] == alm_val[MASK_BIT-1:0]);
endmodule

// File: rtl/alm_irq_gate.sv
module alm_irq_gate (
    input  logic flag,
    input  logic ien,
    input  logic intcn,
    output logic irq_n
);
    assign irq_n = ~(flag & ien & intcn);
endmodule

// File: rtl/alm_match_irq.sv
module alm_match_irq #(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [FIELD_W-1:0] cur_hour,
    input  logic [FIELD_W-1:0] cur_day,
    input  logic [FIELD_W-1:0] cur_date,
    input  logic [FIELD_W-1:0] alm_hour,
    input  logic [FIELD_W-1:0] alm_day,
    input  logic [FIELD_W-1:0] alm_date,
    input  logic               ctl_wr,
    input  logic               ctl_ien,
    input  logic               ctl_intcn,
    input  logic               flag_clr,
    output logic               alarm_flag,
    output logic               irq_n
);
    import alm_pkg::*;

    localparam int NUM_FIELDS = 3;

    logic [NUM_FIELDS-1:0][FIELD_W-1:0] cur_f;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] alm_f;
    logic [NUM_FIELDS-1:0]              hit_vec;
    logic                               hit_all;

    assign cur_f = {cur_date, cur_day, cur_hour};
    assign alm_f = {alm_date, alm_day, alm_hour};

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        alm_field_cmp #(.W(FIELD_W)) u_cmp (
            .cur_val (cur_f[g]),
            .alm_val (alm_f[g]),
            .hit     (hit_vec[g])
        );
    end

    assign hit_all = &hit_vec;

    alm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_wr) begin
            st_d.ien   = ctl_ien;
            st_d.intcn = ctl_intcn;
        end
        if (flag_clr) begin
            st_d.flag = 1'b0;
        end
        // a fresh match outranks a clear in the same cycle
        if (tick && hit_all) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ALM_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign alarm_flag = st_q.flag;

    alm_irq_gate u_gate (
        .flag  (st_q.flag),
        .ien   (st_q.ien),
        .intcn (st_q.intcn),
        .irq_n (irq_n)
    );
endmodule

// File: rtl/alm_match_irq_chk.sv
module alm_match_irq_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic hit_all,
    input logic flag_clr,
    input logic ctl_wr,
    input logic alarm_flag,
    input logic irq_n
);
    a_r2_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hit_all) |=> alarm_flag);

    // R4: a clear with no competing match empties the flag
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(tick && hit_all)) |=> !alarm_flag);

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !flag_clr) |=> $stable(alarm_flag));

    a_r3_no_tick_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !alarm_flag) |=> !alarm_flag);

    a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> alarm_flag);

    a_r8_gate_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr && !tick && !flag_clr) |=> $stable(irq_n));
endmodule

bind alm_match_irq alm_match_irq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .hit_all    (hit_all),
    .flag_clr   (flag_clr),
    .ctl_wr     (ctl_wr),
    .alarm_flag (alarm_flag),
    .irq_n      (irq_n)
);

// File: tb/tb_alm_match_irq.sv
module tb_alm_match_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] cur_hour = '0, cur_day = '0, cur_date = '0;
    logic [7:0] alm_hour = '0, alm_day = '0, alm_date = '0;
    logic       ctl_wr = 1'b0, ctl_ien = 1'b0, ctl_intcn = 1'b0;
    logic       flag_clr = 1'b0;
    logic       alarm_flag, irq_n;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    alm_match_irq dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cur_hour(cur_hour), .cur_day(cur_day), .cur_date(cur_date),
        .alm_hour(alm_hour), .alm_day(alm_day), .alm_date(alm_date),
        .ctl_wr(ctl_wr), .ctl_ien(ctl_ien), .ctl_intcn(ctl_intcn),
        .flag_clr(flag_clr), .alarm_flag(alarm_flag), .irq_n(irq_n)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    task automatic chk(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        tick = 1'b0;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic trial(input logic [7:0] ch, cd, cdt, ah, ad, adt,
                         input logic exp, input string req);
        clear_flag();
        cur_hour = ch; cur_day = cd; cur_date = cdt;
        alm_hour = ah; alm_day = ad; alm_date = adt;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk(alarm_flag, exp, req);
    endtask

    task automatic write_ctl(input logic ien, input logic intcn);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_ien = ien; ctl_intcn = intcn;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #23;
        // R7 reset state
        chk(alarm_flag, 1'b0, "R7 flag");
        chk(irq_n, 1'b1, "R7 irq_n");
        rst_n = 1'b1;

        // R1 R2: every 24-hour pair, day and date masked
        for (int h = 0; h < 24; h++)
            for (int a = 0; a < 24; a++)
                trial(bcd(h), 8'h01, 8'h01, bcd(a), 8'h80, 8'h80, h == a, "R2 hour sweep");
        // R1 R2: weekday pairs
        for (int d = 1; d <= 7; d++)
            for (int a = 1; a <= 7; a++)
                trial(8'h00, bcd(d), 8'h01, 8'h80, bcd(a), 8'h80, d == a, "R2 day sweep");
        // R1 R2: date pairs
        for (int d = 1; d <= 31; d++)
            for (int a = 1; a <= 31; a++)
                trial(8'h00, 8'h01, bcd(d), 8'h80, 8'h80, bcd(a), d == a, "R2 date sweep");
        // R1: bit 7 of a time field is ignored
        trial(8'h95, 8'h83, 8'h99, 8'h15, 8'h03, 8'h19, 1'b1, "R1 time bit7 ignored");

        // R1: 12-hour mode with PM (bit6=12h, bit5=PM)
        trial(8'h67, 8'h02, 8'h10, 8'h67, 8'h02, 8'h10, 1'b1, "R1 12h PM match");
        trial(8'h47, 8'h02, 8'h10, 8'h67, 8'h02, 8'h10, 1'b0, "R1 12h AM vs PM");
        trial(8'h07, 8'h02, 8'h10, 8'h47, 8'h02, 8'h10, 1'b0, "R1 24h vs 12h");
        trial(8'h19, 8'h02, 8'h10, 8'h67, 8'h02, 8'h10, 1'b0, "R1 19h vs 7PM");

        // R1 R9: every mask combination with all fields wrong
        for (int m = 0; m < 8; m++)
            trial(8'h11, 8'h05, 8'h22,
                  {m[0], 7'h12}, {m[1], 7'h06}, {m[2], 7'h23},
                  m == 7, "R9 mask combos mismatch");
        // R1: each field alone mismatched, others exact
        trial(8'h11, 8'h05, 8'h22, 8'h12, 8'h05, 8'h22, 1'b0, "R1 hour only off");
        trial(8'h11, 8'h05, 8'h22, 8'h11, 8'h06, 8'h22, 1'b0, "R1 day only off");
        trial(8'h11, 8'h05, 8'h22, 8'h11, 8'h05, 8'h23, 1'b0, "R1 date only off");
        trial(8'h11, 8'h05, 8'h22, 8'h91, 8'h05, 8'h22, 1'b1, "R1 hour masked");

        // R3: matching fields without tick
        clear_flag();
        cur_hour = 8'h08; alm_hour = 8'h08; alm_day = 8'h80; alm_date = 8'h80;
        repeat (3) @(negedge clk);
        chk(alarm_flag, 1'b0, "R3 no tick");

        // R5: flag sticky after match disappears
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        alm_hour = 8'h09;
        repeat (4) @(negedge clk);
        chk(alarm_flag, 1'b1, "R5 sticky");
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk(alarm_flag, 1'b1, "R5 mismatch tick keeps flag");

        // R4: clear, then clear racing a match
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk(alarm_flag, 1'b0, "R4 clear");
        alm_hour = 8'h08;
        flag_clr = 1'b1; tick = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0; tick = 1'b0;
        chk(alarm_flag, 1'b1, "R4 match beats clear");

        // R8: control inputs without write have no effect
        ctl_ien = 1'b1; ctl_intcn = 1'b1;
        repeat (2) @(negedge clk);
        chk(irq_n, 1'b1, "R8 no write no effect");

        // R6: all gating combinations with flag set
        for (int c = 0; c < 4; c++) begin
            write_ctl(c[0], c[1]);
            chk(irq_n, !(c == 3), "R6 gate combo");
        end
        // R6: flag cleared releases irq
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk(irq_n, 1'b1, "R6 cleared flag releases irq");
        // R9: all masked fires on any tick
        trial(8'h23, 8'h07, 8'h31, 8'h80, 8'h80, 8'h80, 1'b1, "R9 all masked");
        chk(irq_n, 1'b0, "R6 irq asserted");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule